// File: doc/BRIEF.md
# Floppy MFM Sync-Aligned Word Assembler

This block sits on the read path of a floppy controller. It receives the raw MFM bit stream, one bit for each single-cycle bit strobe. The strobes are already synchronised to the system clock. The block watches the most recent 16 received bits for the sync mark. Once it finds the mark, it packs the stream into 16-bit words whose boundaries line up with that mark. Each finished word is presented on a 16-bit bus, and a one-cycle DMA request tells the DMA controller that a word can be taken.

The words stay raw MFM: clock bits are not removed and nothing is decoded. Decoding is left to software or to a later stage. A sync mark that turns up in the middle of a word moves the word boundary to it. The block therefore locks cleanly on the usual back-to-back pair of marks that follows the preamble, even when a preamble word is damaged. The only storage is one 16-bit shift register and one 16-bit output register, so a bit reaches the bus within one word time.

Top module: `mfm_sync_assembler`

## Requirements
- R1: With `syncEnable` high, a strobe after which the last 16 received bits equal `SYNC_WORD` (default 0x4489) emits that pattern as a word and restarts the word count from zero.
- R2: After a sync word, every 16th further strobe emits a word holding those 16 bits unchanged, with the first-received bit in bit 15.
- R3: From reset until the first sync match, no word is emitted, whatever preamble is received, including 0x2AAA or other damaged preamble words.
- R4: `dmaReq` is high for exactly the one clock that follows the strobe completing a word.
- R5: `dataOut` changes only together with `dmaReq` and holds its value until the next word completes.
- R6: `wordSync` is high only in a `dmaReq` cycle whose word was a sync match, and `dataOut` then equals `SYNC_WORD`.
- R7: Two sync words received back to back each produce one word with `wordSync` set, and no extra word is emitted.
- R8: A sync match that lands in the middle of a word moves the word boundary to it. The partly built word is not emitted, and the next word follows 16 strobes after the match.
- R9: With `syncEnable` low, matches are ignored. The block emits nothing while it is still searching, and once locked it keeps its existing 16-strobe cadence without re-aligning.
- R10: A synchronous reset clears `dataOut`, `dmaReq` and `wordSync` to zero and returns the block to searching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitStrobe | input | 1 | One-cycle strobe marking a valid serial bit |
| bitIn | input | 1 | Raw MFM data bit, sampled when `bitStrobe` is high |
| syncEnable | input | 1 | Enables sync matching when high |
| dataOut | output | 16 | Last assembled raw MFM word |
| dmaReq | output | 1 | One-cycle request, a new word is on `dataOut` |
| wordSync | output | 1 | The word flagged by `dmaReq` is a sync match |

## Verification
The stream starts with a standard preamble that contains a damaged 0x2AAA word, then a doubled sync mark and data words. This shows that locking depends only on the mark, and that a doubled mark yields exactly two flagged words. A run of five stray bits before a fresh mark while locked produces one misaligned word, 0xAA24, before the mark. This tells a true re-alignment apart from a block that simply keeps counting. A run with matching disabled, first while searching and then while locked, separates "ignore matches" from "stop emitting". A reset in the middle of the stream confirms that the block goes back to searching.

// File: rtl/mfm_sync_pkg.sv
package mfm_sync_pkg;

  // Strobes from the lock controller to the shift datapath
  typedef struct packed {
    logic shift;     // take bitIn into the shift register
    logic emit;      // publish the assembled word
    logic emitSync;  // the published word is a sync match
  } ctlStrobes_t;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lockState_t;

endpackage

// File: rtl/mfm_shift_path.sv
module mfm_shift_path
  import mfm_sync_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD = 16'h4489
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitIn,
  input  ctlStrobes_t       ctl,
  output logic              patHit,
  output logic [WORD_W-1:0] dataOut,
  output logic              dmaReq,
  output logic              wordSync
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;

  // Window as it will look once the current bit is taken
  assign shiftNext = {shiftReg[WORD_W-2:0], bitIn};
  assign patHit    = (shiftNext == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      dataOut  <= '0;
      dmaReq   <= 1'b0;
      wordSync <= 1'b0;
    end else begin
      dmaReq   <= ctl.emit;
      wordSync <= ctl.emit & ctl.emitSync;
      if (ctl.shift) shiftReg <= shiftNext;
      if (ctl.emit)  dataOut  <= shiftNext;
    end
  end

  // R6: a flagged word is always the sync pattern
  a_r6_sync_value: assert property (@(posedge clk) disable iff (rst)
    wordSync |-> (dmaReq && dataOut == SYNC_WORD));

  // R5: output word only moves when a request is raised
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !dmaReq |-> $stable(dataOut));

endmodule

// File: rtl/mfm_lock_ctrl.sv
module mfm_lock_ctrl
  import mfm_sync_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bitStrobe,
  input  logic        syncEnable,
  input  logic        patHit,
  output ctlStrobes_t ctl
);

  localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  lockState_t       lockState;
  logic [CNT_W-1:0] bitCnt;
  logic             syncHit;
  logic             wordDone;
  logic             lastBit;

  assign lastBit  = (bitCnt == LAST_BIT);
  assign syncHit  = bitStrobe & syncEnable & patHit;
  assign wordDone = bitStrobe & (lockState == ST_LOCKED) & lastBit & ~syncHit;

  always_comb begin
    ctl          = '0;
    ctl.shift    = bitStrobe;
    ctl.emit     = syncHit | wordDone;
    ctl.emitSync = syncHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lockState <= ST_SEARCH;
      bitCnt    <= '0;
    end else if (syncHit) begin
      lockState <= ST_LOCKED;
      bitCnt    <= '0;
    end else if (bitStrobe && lockState == ST_LOCKED) begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  // R3: while searching only a sync match may publish a word
  a_r3_search_quiet: assert property (@(posedge clk) disable iff (rst)
    (lockState == ST_SEARCH && ctl.emit) |-> ctl.emitSync);

  // R1: a sync match leaves the controller locked with a fresh count
  a_r1_restart: assert property (@(posedge clk) disable iff (rst)
    syncHit |=> (lockState == ST_LOCKED && bitCnt == '0));

  // R9: a match is never honoured when matching is disabled
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    ctl.emitSync |-> syncEnable);

endmodule

// File: rtl/mfm_sync_assembler.sv
module mfm_sync_assembler
  import mfm_sync_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD = 16'h4489
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitStrobe,
  input  logic              bitIn,
  input  logic              syncEnable,
  output logic [WORD_W-1:0] dataOut,
  output logic              dmaReq,
  output logic              wordSync
);

  ctlStrobes_t ctl;
  logic        patHit;

  mfm_lock_ctrl #(
    .WORD_W(WORD_W)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitStrobe (bitStrobe),
    .syncEnable(syncEnable),
    .patHit    (patHit),
    .ctl       (ctl)
  );

  mfm_shift_path #(
    .WORD_W   (WORD_W),
    .SYNC_WORD(SYNC_WORD)
  ) i_path (
    .clk     (clk),
    .rst     (rst),
    .bitIn   (bitIn),
    .ctl     (ctl),
    .patHit  (patHit),
    .dataOut (dataOut),
    .dmaReq  (dmaReq),
    .wordSync(wordSync)
  );

  // R4: a request follows the strobe that completed the word
  a_r4_after_strobe: assert property (@(posedge clk) disable iff (rst)
    dmaReq |-> $past(bitStrobe));

  // R10: the cycle after reset shows a cleared output
  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!dmaReq && !wordSync && dataOut == '0));

endmodule

// File: tb/test_mfm_sync_assembler.sv
module test_mfm_sync_assembler;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SYNC = 16'h4489;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitStrobe = 1'b0;
  logic        bitIn = 1'b0;
  logic        syncEnable = 1'b0;
  logic [15:0] dataOut;
  logic        dmaReq;
  logic        wordSync;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int gapSeed = 7;

  // behavioural reference state
  int unsigned mWin = 0;
  int          mCount = 0;
  bit          mLocked = 0;
  bit          expDma = 0;
  bit          expSync = 0;
  logic [15:0] expData = '0;

  logic [15:0] capWords[$];
  bit          capFlags[$];

  mfm_sync_assembler i_mfm_sync_assembler (
    .clk       (clk),
    .rst       (rst),
    .bitStrobe (bitStrobe),
    .bitIn     (bitIn),
    .syncEnable(syncEnable),
    .dataOut   (dataOut),
    .dmaReq    (dmaReq),
    .wordSync  (wordSync)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, updated on the same edge as the design
  always @(posedge clk) begin
    if (rst) begin
      mWin = 0; mCount = 0; mLocked = 0;
      expDma = 0; expSync = 0; expData = '0;
    end else begin
      expDma = 0; expSync = 0;
      if (bitStrobe) begin
        mWin = ((mWin << 1) | bitIn) & 32'hFFFF;
        if (syncEnable && mWin == SYNC) begin
          mLocked = 1; mCount = 0;
          expDma = 1; expSync = 1; expData = mWin[15:0];
        end else if (mLocked) begin
          mCount++;
          if (mCount == 16) begin
            mCount = 0; expDma = 1; expData = mWin[15:0];
          end
        end
      end
    end
  end

  // per-clock comparison and word capture, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(dmaReq == expDma, "R4 dmaReq", dmaReq, expDma);
      check(dataOut == expData, "R5 dataOut", dataOut, expData);
      check(wordSync == expSync, "R6 wordSync", wordSync, expSync);
      if (dmaReq) begin
        capWords.push_back(dataOut);
        capFlags.push_back(wordSync);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic sendBit(input bit b);
    @(negedge clk);
    bitStrobe = 1'b1; bitIn = b;
    @(negedge clk);
    bitStrobe = 1'b0;
    gapSeed = (gapSeed * 5 + 3) % 17;
    for (int g = 0; g < gapSeed % 3; g++) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic settle();
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R10: cleared outputs while in reset
    check(dataOut == 16'h0 && !dmaReq && !wordSync, "R10 reset state",
          {dmaReq, wordSync, dataOut}, 0);
    rst = 1'b0;
  endtask

  initial begin
    // Scenario A: preamble with a damaged word, doubled mark, data
    syncEnable = 1'b1;
    doReset();
    capWords.delete(); capFlags.delete();
    sendWord(16'hAAAA); sendWord(16'h2AAA);
    check(capWords.size() == 0, "R3 no word before sync", capWords.size(), 0);
    sendWord(SYNC); sendWord(SYNC);
    sendWord(16'h9249); sendWord(16'h5555); sendWord(16'hAAAA);
    settle();
    check(capWords.size() == 5, "R1 word count after lock", capWords.size(), 5);
    if (capWords.size() == 5) begin
      check(capWords[0] == SYNC && capFlags[0], "R1 first word is sync", capWords[0], SYNC);
      check(capFlags[1] && capWords[1] == SYNC, "R7 second sync flagged", capFlags[1], 1);
      check(capWords[2] == 16'h9249 && !capFlags[2], "R2 raw word 1", capWords[2], 16'h9249);
      check(capWords[4] == 16'hAAAA, "R2 raw word 3", capWords[4], 16'hAAAA);
    end

    // Scenario B: five stray bits then a fresh mark while locked
    capWords.delete(); capFlags.delete();
    sendBit(1); sendBit(0); sendBit(1); sendBit(0); sendBit(1);
    sendWord(SYNC); sendWord(16'h5555);
    settle();
    check(capWords.size() == 3, "R8 words around realign", capWords.size(), 3);
    if (capWords.size() == 3) begin
      check(capWords[0] == 16'hAA24, "R8 misaligned word", capWords[0], 16'hAA24);
      check(capWords[1] == SYNC && capFlags[1], "R8 realigned sync", capWords[1], SYNC);
      check(capWords[2] == 16'h5555, "R8 word after realign", capWords[2], 16'h5555);
    end

    // Scenario C: matching disabled while searching, then while locked
    doReset();
    syncEnable = 1'b0;
    capWords.delete(); capFlags.delete();
    sendWord(16'hAAAA); sendWord(SYNC); sendWord(SYNC); sendWord(16'h5555);
    settle();
    check(capWords.size() == 0, "R9 disabled search silent", capWords.size(), 0);
    syncEnable = 1'b1;
    sendWord(SYNC); sendWord(16'h5555);
    settle();
    check(capWords.size() == 2, "R1 lock after enable", capWords.size(), 2);
    capWords.delete(); capFlags.delete();
    syncEnable = 1'b0;
    sendBit(1); sendBit(0); sendBit(1);
    sendWord(SYNC); sendWord(16'h5555);
    settle();
    check(capWords.size() == 2, "R9 cadence kept", capWords.size(), 2);
    if (capWords.size() == 2) begin
      check(capWords[0] == 16'hA891 && !capFlags[0], "R9 no realign", capWords[0], 16'hA891);
      check(capWords[1] == 16'h2AAA, "R9 next word", capWords[1], 16'h2AAA);
    end

    // Scenario D: reset while locked returns to searching
    syncEnable = 1'b1;
    doReset();
    capWords.delete(); capFlags.delete();
    sendWord(16'h5555); sendWord(16'hAAAA);
    settle();
    check(capWords.size() == 0, "R10 searching after reset", capWords.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule